// File: doc/BRIEF.md
# Frequency Synthesizer Serial Programming Register

This block is the three-wire programming port of a frequency synthesizer. A host drives a serial clock, a data line and a load-enable line. The block oversamples all three with the chip's own clock, shifts one data bit into a 21-bit holding word on every rising edge of the serial clock, and copies part of that word into a latched register on every rising edge of load enable. The two lowest bits of the word are a control code that selects the destination: either the reference-divider register or the main-divider register.

The reference-divider register holds the reference divide ratio and the lock-detect precision bit. The main-divider register holds the swallow count (A), the main count (B) and the charge-pump current bit. Before any value is latched, the block checks it: a divide ratio below the minimum, a main count below the minimum, a swallow count larger than the main count, or any test-mode bit set rejects the load. A rejected load leaves the old contents in place and raises an error strobe for one clock. The latched fields drive the synthesizer's counters directly.

Top module: `pll_serial_prog`

## Requirements
- R1: After a synchronous active-low reset, every latched field output is zero and load_err_o is low.
- R2: Each rising edge of ser_clk_i shifts ser_data_i into bit 0 of the holding word and moves every other bit up by one place, so a word is sent most significant bit first. Extra clocks beyond 21 push the oldest bits out, and only the last 21 bits count.
- R3: The control code is word bit 0 (C1) and word bit 1 (C2). C1=0,C2=0 addresses the reference register. C1=1,C2=0 addresses the main register. The other two codes change no output and raise no error.
- R4: A reference load puts word bits 15..2 on ref_div_o (bit 2 is the LSB) and word bit 20 on lock_prec_o (1 = five consecutive reference cycles, 0 = three).
- R5: A reference load whose divide ratio is below 3, or whose test bits (word bits 19..16) are not all zero, is rejected.
- R6: A main load puts word bits 6..2 on swallow_o (bit 2 is the LSB) and word bits 19..7 on main_cnt_o (bit 7 is the LSB).
- R7: A main load whose main count is below 3, or whose swallow count is larger than its main count, is rejected.
- R8: A main load puts word bit 20 on cp_high_o (1 = high current, 1 mA; 0 = low current, 250 µA).
- R9: A rejected load keeps every latched output unchanged and drives load_err_o high for exactly one clock cycle.
- R10: When a rising edge of load enable and a rising edge of the serial clock are seen in the same clock cycle, the latch takes the holding word as it was before that shift, and the new bit is still shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_le_i | input | 1 | Load enable; its rising edge latches the word |
| ref_div_o | output | 14 | Latched reference divide ratio |
| lock_prec_o | output | 1 | Latched lock-detect precision (1 = five cycles) |
| swallow_o | output | 5 | Latched swallow count A |
| main_cnt_o | output | 13 | Latched main count B |
| cp_high_o | output | 1 | Latched charge-pump current select (1 = high) |
| load_err_o | output | 1 | One-cycle strobe for a rejected load |

## Verification
The shift of a new bit and the latch of the holding word can fall in the same cycle. That happens when the serial clock and load enable rise together. The bench raises both lines at the same instant, so they pass through identical synchronizers and are detected in the same cycle. It then checks that the latched fields match the word as it stood before that bit. A second load-enable pulse with no clock in between must then latch the shifted word, which shows that the coincident bit was not lost.

// File: rtl/pll_serial_prog_pkg.sv
// Package: shared widths, control codes and field layouts for the
// synthesizer programming port. Assumes the 21-bit word with the control
// code in its two lowest bits and a 19-bit payload above it.
package pll_serial_prog_pkg;

    localparam int WORD_W = 21;
    localparam int CODE_W = 2;
    localparam int PAY_W  = WORD_W - CODE_W;
    localparam int RDIV_W = 14;
    localparam int TEST_W = 4;
    localparam int SWAL_W = 5;
    localparam int MAIN_W = 13;

    // Control code, written as {C2, C1}
    typedef enum logic [CODE_W-1:0] {
        CODE_REF  = 2'b00,
        CODE_MAIN = 2'b01,
        CODE_UN2  = 2'b10,
        CODE_UN3  = 2'b11
    } sel_code_e;

    // Reference payload, most significant field first
    typedef struct packed {
        logic              ld_prec;
        logic [TEST_W-1:0] test;
        logic [RDIV_W-1:0] rdiv;
    } ref_pay_t;

    // Main-divider payload, most significant field first
    typedef struct packed {
        logic              cp_high;
        logic [MAIN_W-1:0] bcnt;
        logic [SWAL_W-1:0] acnt;
    } main_pay_t;

endpackage

// File: rtl/pll_serial_sync.sv
// Module: brings one asynchronous serial line into the clk domain through a
// flop chain and flags its rising edge for one cycle.
// Assumes each level is held for at least STAGES+1 clk cycles.
module pll_serial_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Synchronizer chain; the first stage samples the raw line
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;

    // R2 R10: an edge strobe never lasts two cycles
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pll_serial_shift.sv
// Module: the holding shift register. On each shift strobe the data bit
// enters bit 0 and older bits move toward the top; the top bit is lost.
// Assumes shift_i lasts one cycle for each serial clock edge.
module pll_serial_shift #(
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] word_o
);
    // Shift in a bit on each strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)       word_o <= '0;
        else if (shift_i) word_o <= {word_o[WIDTH-2:0], din_i};
    end

    // R2: the holding word moves only on a shift strobe
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(word_o));

endmodule

// File: rtl/pll_serial_latch.sv
// Module: decodes the control code of the holding word on a load strobe,
// range-checks the addressed payload, and updates the reference or main
// register only when the payload is legal; otherwise pulses an error.
// Assumes load_i lasts one cycle and word_i is the pre-shift holding word.
module pll_serial_latch
    import pll_serial_prog_pkg::*;
#(
    parameter int RDIV_MIN = 3,
    parameter int MAIN_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [RDIV_W-1:0] rdiv_o,
    output logic              ld_prec_o,
    output logic [SWAL_W-1:0] acnt_o,
    output logic [MAIN_W-1:0] bcnt_o,
    output logic              cp_high_o,
    output logic              err_o
);
    localparam logic [RDIV_W-1:0] RDIV_MIN_V = RDIV_W'(RDIV_MIN);
    localparam logic [MAIN_W-1:0] MAIN_MIN_V = MAIN_W'(MAIN_MIN);

    sel_code_e  code;
    ref_pay_t   ref_pay;
    main_pay_t  main_pay;
    logic       ref_ok;
    logic       main_ok;
    logic       ref_upd;
    logic       main_upd;
    logic       reject;

    // Split the holding word and judge both payload views
    always_comb begin
        code     = sel_code_e'(word_i[CODE_W-1:0]);
        ref_pay  = ref_pay_t'(word_i[WORD_W-1:CODE_W]);
        main_pay = main_pay_t'(word_i[WORD_W-1:CODE_W]);
        ref_ok   = (ref_pay.rdiv >= RDIV_MIN_V) && (ref_pay.test == '0);
        main_ok  = (main_pay.bcnt >= MAIN_MIN_V) &&
                   ({{(MAIN_W-SWAL_W){1'b0}}, main_pay.acnt} <= main_pay.bcnt);
        ref_upd  = load_i && (code == CODE_REF)  && ref_ok;
        main_upd = load_i && (code == CODE_MAIN) && main_ok;
        reject   = load_i && (((code == CODE_REF)  && !ref_ok) ||
                              ((code == CODE_MAIN) && !main_ok));
    end

    // Reference register: divide ratio and lock precision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdiv_o    <= '0;
            ld_prec_o <= 1'b0;
        end else if (ref_upd) begin
            rdiv_o    <= ref_pay.rdiv;
            ld_prec_o <= ref_pay.ld_prec;
        end
    end

    // Main register: swallow count, main count, pump current
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acnt_o    <= '0;
            bcnt_o    <= '0;
            cp_high_o <= 1'b0;
        end else if (main_upd) begin
            acnt_o    <= main_pay.acnt;
            bcnt_o    <= main_pay.bcnt;
            cp_high_o <= main_pay.cp_high;
        end
    end

    // Error strobe for a rejected load
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= reject;
    end

    // R9: the error strobe is a single cycle
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R9: a rejected load leaves the reference register unchanged
    ref_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(rdiv_o) && $stable(ld_prec_o));

    // R9: a rejected load leaves the main register unchanged
    main_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(acnt_o) && $stable(bcnt_o) && $stable(cp_high_o));

    // R3: without a load strobe no latched field moves
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(rdiv_o) && $stable(bcnt_o) && $stable(acnt_o));

    // R5: an accepted reference ratio is within range
    ref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd |=> rdiv_o >= RDIV_MIN_V);

    // R7: an accepted main load has B at least the minimum and A not above B
    main_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_upd |=> (bcnt_o >= MAIN_MIN_V) &&
                     ({{(MAIN_W-SWAL_W){1'b0}}, acnt_o} <= bcnt_o));

endmodule

// File: rtl/pll_serial_prog.sv
// Module: top of the synthesizer programming port. Synchronizes the three
// serial lines, feeds the holding shift register and the checked latch.
// Assumes serial high and low times of at least SYNC_STAGES+1 clk cycles.
module pll_serial_prog
    import pll_serial_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RDIV_MIN    = 3,
    parameter int MAIN_MIN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              ser_le_i,
    output logic [RDIV_W-1:0] ref_div_o,
    output logic              lock_prec_o,
    output logic [SWAL_W-1:0] swallow_o,
    output logic [MAIN_W-1:0] main_cnt_o,
    output logic              cp_high_o,
    output logic              load_err_o
);
    logic              sclk_lvl, sclk_rise;
    logic              sdat_lvl, sdat_rise;
    logic              sle_lvl,  sle_rise;
    logic [WORD_W-1:0] hold_word;

    pll_serial_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .async_i(ser_clk_i),
        .level_o(sclk_lvl), .rise_o(sclk_rise));

    pll_serial_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .async_i(ser_data_i),
        .level_o(sdat_lvl), .rise_o(sdat_rise));

    pll_serial_sync #(.STAGES(SYNC_STAGES)) u_sync_le (
        .clk(clk), .rst_n(rst_n), .async_i(ser_le_i),
        .level_o(sle_lvl), .rise_o(sle_rise));

    pll_serial_shift #(.WIDTH(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_i(sclk_rise),
        .din_i(sdat_lvl), .word_o(hold_word));

    pll_serial_latch #(.RDIV_MIN(RDIV_MIN), .MAIN_MIN(MAIN_MIN)) u_latch (
        .clk(clk), .rst_n(rst_n), .load_i(sle_rise), .word_i(hold_word),
        .rdiv_o(ref_div_o), .ld_prec_o(lock_prec_o), .acnt_o(swallow_o),
        .bcnt_o(main_cnt_o), .cp_high_o(cp_high_o), .err_o(load_err_o));

    // R1: outputs are cleared in the cycle after reset is applied
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ref_div_o == '0) && (main_cnt_o == '0) && !load_err_o);

    // Levels other than the data line are used only through their edges
    logic unused_ok;
    assign unused_ok = sclk_lvl ^ sdat_rise ^ sle_lvl;

endmodule

// File: tb/pll_serial_prog_bench.sv
// Bench: directed corner cases plus seeded random words, compared against
// a reference model kept in bench functions.
module pll_serial_prog_bench;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        sle = 1'b0;
    logic [13:0] ref_div;
    logic        lock_prec;
    logic [4:0]  swallow;
    logic [12:0] main_cnt;
    logic        cp_high;
    logic        load_err;

    int checks = 0;
    int fails  = 0;
    int err_seen = 0;
    int err_exp  = 0;
    logic [13:0] e_r  = '0;
    logic        e_ld = 1'b0;
    logic [4:0]  e_a  = '0;
    logic [12:0] e_b  = '0;
    logic        e_cp = 1'b0;

    always #5 clk = ~clk;

    pll_serial_prog u_pll_serial_prog (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata),
        .ser_le_i(sle), .ref_div_o(ref_div), .lock_prec_o(lock_prec),
        .swallow_o(swallow), .main_cnt_o(main_cnt), .cp_high_o(cp_high),
        .load_err_o(load_err));

    // Count every cycle the error strobe is high
    always @(posedge clk) if (rst_n && load_err) err_seen++;

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "ref_div",   int'(ref_div),   int'(e_r));
        check(tag, "lock_prec", int'(lock_prec), int'(e_ld));
        check(tag, "swallow",   int'(swallow),   int'(e_a));
        check(tag, "main_cnt",  int'(main_cnt),  int'(e_b));
        check(tag, "cp_high",   int'(cp_high),   int'(e_cp));
        check(tag, "err_count", err_seen,        err_exp);
    endtask

    // Reference model of one load of a 21-bit word
    task automatic model_load(input logic [20:0] w);
        logic [13:0] r;
        logic [4:0]  a;
        logic [12:0] b;
        r = w[15:2];
        a = w[6:2];
        b = w[19:7];
        if (w[1:0] == 2'b00) begin
            if (r < 14'd3 || w[19:16] != 4'd0) err_exp++;
            else begin e_r = r; e_ld = w[20]; end
        end else if (w[1:0] == 2'b01) begin
            if (b < 13'd3 || {8'd0, a} > b) err_exp++;
            else begin e_a = a; e_b = b; e_cp = w[20]; end
        end
    endtask

    function automatic logic [20:0] ref_word(input logic ld, input logic [3:0] t,
                                              input logic [13:0] r);
        return {ld, t, r, 2'b00};
    endfunction

    function automatic logic [20:0] main_word(input logic cp, input logic [12:0] b,
                                               input logic [4:0] a);
        return {cp, b, a, 2'b01};
    endfunction

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) sdata = w[i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic pulse_le();
        @(negedge clk) sle = 1'b1;
        repeat (8) @(negedge clk);
        sle = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic load(input logic [20:0] w, input string tag);
        send_bits({11'd0, w}, 21);
        pulse_le();
        model_load(w);
        check_all(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [20:0] w1;
        logic [20:0] w;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R1");

        // Known main word: A = 8, B = 31, high current
        load(21'h100FA1, "R6");
        check("R6", "swallow_fixed", int'(swallow), 8);
        check("R6", "main_fixed", int'(main_cnt), 31);
        check("R8", "cp_fixed", int'(cp_high), 1);

        load(ref_word(1'b1, 4'd0, 14'd3), "R4");
        load(ref_word(1'b0, 4'd0, 14'd16383), "R4");
        load(ref_word(1'b1, 4'd0, 14'd2), "R5");
        load(ref_word(1'b1, 4'd4, 14'd100), "R5");
        load(main_word(1'b0, 13'd3, 5'd3), "R7");
        load(main_word(1'b1, 13'd9, 5'd10), "R7");
        load(main_word(1'b1, 13'd2, 5'd0), "R7");
        load(main_word(1'b0, 13'd8191, 5'd31), "R8");
        load({1'b1, 18'h3FFFF, 2'b10}, "R3");
        load({1'b1, 18'h00055, 2'b11}, "R3");
        load(ref_word(1'b0, 4'd15, 14'd0), "R9");

        // Extra clocks: four leading junk bits fall off the top
        w = main_word(1'b1, 13'd500, 5'd17);
        send_bits({7'd0, 4'hB, w}, 25);
        pulse_le();
        model_load(w);
        check_all("R2");

        // Serial clock and load enable rise together
        w1 = ref_word(1'b1, 4'd0, 14'd4097);
        send_bits({11'd0, w1}, 21);
        @(negedge clk) sdata = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        sle  = 1'b1;
        repeat (8) @(negedge clk);
        sclk = 1'b0;
        sle  = 1'b0;
        repeat (6) @(negedge clk);
        model_load(w1);
        check_all("R10");
        pulse_le();
        model_load({w1[19:0], 1'b1});
        check_all("R10");

        // Seeded random words
        for (int k = 0; k < 150; k++) begin
            w = 21'($urandom());
            if ($urandom() % 4 != 0) w[19:16] = 4'd0;
            if ($urandom() % 8 == 0) w[19:7] = 13'($urandom() % 4);
            load(w, "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule